// File: doc/BRIEF.md
# ADC Start and Readout Sequencer

This block sits between a simple synchronous host bus and the control pins of a 12-bit successive-approximation converter. A conversion begins on a rising edge of a timer tick or on any host write to the start address. On that event the block drops the active-low read/convert line for a set number of clock cycles. It then raises the converter enable after a fixed delay and holds it for a set width, so the converter samples only once read/convert, byte address and chip select have settled.

The 12-bit result comes back through one 8-bit data port in two reads. The first read uses byte address 0 and returns the upper eight bits. The host then sets byte address 1 and reads again to get the lower four bits in the top nibble of the byte. After that low-half read the byte address drops back to 0 by itself, so the block is ready for the next conversion. Chip select and byte address come from host registers and cannot change while a conversion pulse is running.

Top module: `adc_start_readout`

## Requirements
- R1: While reset is asserted: adcRcN = 1, adcCe = 0, adcCsN = 1, adcA0 = 0, busRData = 0.
- R2: A host write to address 0 (start) with any data, while chip select is on and no conversion is running, drives adcRcN low from the cycle after the write edge for exactly RC_W cycles.
- R3: A rising edge of timerTick starts a conversion with the same timing as R2. Holding timerTick high starts only one conversion.
- R4: During a conversion adcCe is high for exactly CE_W cycles, starting CE_DLY cycles after adcRcN fell. adcRcN is already low when adcCe rises.
- R5: A start request (timer edge or start write) is ignored while a conversion is running, and the running pulse is not lengthened. A start request is also ignored while chip select is off.
- R6: A host write to address 3 sets chip select from data bit 0 (adcCsN = not bit 0). While a conversion is running, writes to address 3 and address 2 are ignored.
- R7: A host write to address 2 sets adcA0 from data bit 0 in the next cycle.
- R8: A host read of address 1 (data) outside a conversion raises adcCe for exactly one cycle, the cycle after the read edge. adcRcN stays high. busRData then carries result[11:4] if adcA0 was 0, or {result[3:0],4'h0} if adcA0 was 1, and holds that value until the next accepted read.
- R9: After an accepted read with adcA0 = 1, adcA0 is 0 in the following cycle.
- R10: A read of the data port during a conversion produces no adcCe pulse of its own, leaves adcA0 unchanged and leaves busRData unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timerTick | input | 1 | Timer output; a rising edge requests a conversion |
| busAddr | input | ADDR_W | Host register address |
| busWr | input | 1 | Host write strobe, one cycle |
| busRd | input | 1 | Host read strobe, one cycle |
| busWData | input | 8 | Host write data |
| busRData | output | 8 | Byte read from the data port |
| adcResult | input | 12 | Converter result word |
| adcCsN | output | 1 | Converter chip select, active low |
| adcRcN | output | 1 | Read/convert line, low = convert |
| adcCe | output | 1 | Converter enable, active high |
| adcA0 | output | 1 | Byte address: 0 = upper byte, 1 = low nibble |

## Verification
Conversions are started by start writes that carry non-zero data and by a timer tick held high. The held tick shows whether the block starts on an edge or on a level. The readout runs through a table of result words: all zeros, all ones and mixed bit patterns, each read with both byte-address values. These show whether the halves are swapped, whether the nibble is misaligned and whether the auto-return of the byte address works. Reads, register writes and extra starts are also issued in the middle of a pulse, and chip select is turned off before a start. These cases separate a correctly blocked request from one that lengthens or corrupts the running sequence.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // strobes from the sequencer control to the register datapath
  typedef struct packed {
    logic ldCtrl;    // accepted write of the chip-select register
    logic ldBsel;    // accepted write of the byte-select register
    logic takeRead;  // accepted read of the data port
    logic busy;      // conversion pulse in progress
  } seqStrobes_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int ADDR_START = 0,
  parameter int ADDR_DATA  = 1,
  parameter int ADDR_BSEL  = 2,
  parameter int ADDR_CTRL  = 3,
  parameter int RC_W       = 50,
  parameter int CE_DLY     = 4,
  parameter int CE_W       = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              timerTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              csOn,
  output seqStrobes_t       strb,
  output logic              rcN,
  output logic              ceOut
);

  localparam int CE_END = CE_DLY + CE_W;
  localparam int SPAN   = (RC_W > CE_END) ? RC_W : CE_END;
  localparam int CNT_W  = $clog2(SPAN + 1);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(SPAN - 1);
  localparam logic [CNT_W-1:0] RC_LIMIT  = CNT_W'(RC_W);
  localparam logic [CNT_W-1:0] CE_FIRST  = CNT_W'(CE_DLY);
  localparam logic [CNT_W-1:0] CE_LIMIT  = CNT_W'(CE_END);

  logic             tickQ;
  logic             tickRise;
  logic             startReq;
  logic             startGo;
  logic             readGo;
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             ceRd;
  logic             rcLow;
  logic             ceConv;

  assign tickRise = timerTick & ~tickQ;
  assign startReq = tickRise | (busWr && busAddr == ADDR_W'(ADDR_START));
  assign startGo  = startReq & ~busy & csOn;
  assign readGo   = busRd && busAddr == ADDR_W'(ADDR_DATA) && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickQ <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
      ceRd  <= 1'b0;
    end else begin
      tickQ <= timerTick;
      ceRd  <= readGo;
      if (startGo) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST_CNT) busy <= 1'b0;
      end
    end
  end

  assign rcLow  = busy && (cnt < RC_LIMIT);
  assign ceConv = busy && (cnt >= CE_FIRST) && (cnt < CE_LIMIT);
  assign rcN    = ~rcLow;
  assign ceOut  = ceConv | ceRd;

  assign strb.ldCtrl   = busWr && busAddr == ADDR_W'(ADDR_CTRL) && !busy;
  assign strb.ldBsel   = busWr && busAddr == ADDR_W'(ADDR_BSEL) && !busy;
  assign strb.takeRead = readGo;
  assign strb.busy     = busy;

  AST_START_DROPS_RC: assert property (@(posedge clk) disable iff (!rstN)
    startGo |=> !rcN);  // R2

  AST_CE_AFTER_RC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ceConv) |-> ($past(rcN) == 1'b0));  // R4

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rcN) |-> $past(!busy));  // R5

  AST_READ_PULSES_CE: assert property (@(posedge clk) disable iff (!rstN)
    readGo |=> (ceOut && rcN));  // R8

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [BYTE_W-1:0] busWData,
  input  logic [RES_W-1:0]  adcResult,
  output logic              csOn,
  output logic              a0,
  output logic [BYTE_W-1:0] rdData
);

  localparam int LOW_W = RES_W - BYTE_W;
  localparam int PAD_W = BYTE_W - LOW_W;

  logic [BYTE_W-1:0] hiByte;
  logic [BYTE_W-1:0] loByte;
  logic              unusedWBits;

  assign hiByte      = adcResult[RES_W-1 -: BYTE_W];
  assign loByte      = {adcResult[LOW_W-1:0], {PAD_W{1'b0}}};
  assign unusedWBits = ^busWData[BYTE_W-1:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csOn   <= 1'b0;
      a0     <= 1'b0;
      rdData <= '0;
    end else begin
      if (strb.ldCtrl) csOn <= busWData[0];
      if (strb.ldBsel)               a0 <= busWData[0];
      else if (strb.takeRead && a0)  a0 <= 1'b0;
      if (strb.takeRead) rdData <= a0 ? loByte : hiByte;
    end
  end

  AST_CS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && $past(strb.busy)) |-> $stable(csOn));  // R6

  AST_A0_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeRead && a0) |=> !a0);  // R9

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.takeRead |=> $stable(rdData));  // R10

endmodule

// File: rtl/adc_start_readout.sv
module adc_start_readout
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int ADDR_START = 0,
  parameter int ADDR_DATA  = 1,
  parameter int ADDR_BSEL  = 2,
  parameter int ADDR_CTRL  = 3,
  parameter int RC_W       = 50,
  parameter int CE_DLY     = 4,
  parameter int CE_W       = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              timerTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWData,
  output logic [7:0]        busRData,
  input  logic [11:0]       adcResult,
  output logic              adcCsN,
  output logic              adcRcN,
  output logic              adcCe,
  output logic              adcA0
);

  seqStrobes_t strb;
  logic        csOn;
  logic        a0;

  adc_seq_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_START(ADDR_START), .ADDR_DATA(ADDR_DATA),
    .ADDR_BSEL(ADDR_BSEL), .ADDR_CTRL(ADDR_CTRL),
    .RC_W(RC_W), .CE_DLY(CE_DLY), .CE_W(CE_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .timerTick(timerTick), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .csOn(csOn), .strb(strb),
    .rcN(adcRcN), .ceOut(adcCe)
  );

  adc_seq_dp #(.RES_W(12), .BYTE_W(8)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busWData(busWData),
    .adcResult(adcResult), .csOn(csOn), .a0(a0), .rdData(busRData)
  );

  assign adcCsN = ~csOn;
  assign adcA0  = a0;

endmodule

// File: tb/adc_start_readout_tb.sv
module adc_start_readout_tb_top;

  localparam int RC_W   = 12;
  localparam int CE_DLY = 3;
  localparam int CE_W   = 6;
  localparam int SPAN   = 12;
  localparam logic [1:0] A_START = 2'd0;
  localparam logic [1:0] A_DATA  = 2'd1;
  localparam logic [1:0] A_BSEL  = 2'd2;
  localparam logic [1:0] A_CTRL  = 2'd3;

  // {a0, result[11:0], expected byte}
  localparam logic [20:0] VEC [0:5] = '{
    21'h0ABCAB, 21'h1ABCC0, 21'h000000,
    21'h1FFFF0, 21'h0FFFFF, 21'h15A330
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       timerTick = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWData = '0;
  logic [7:0] busRData;
  logic [11:0] adcResult = '0;
  logic       adcCsN, adcRcN, adcCe, adcA0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_start_readout #(.RC_W(RC_W), .CE_DLY(CE_DLY), .CE_W(CE_W)) dut_i (
    .clk(clk), .rstN(rstN), .timerTick(timerTick), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWData(busWData), .busRData(busRData),
    .adcResult(adcResult), .adcCsN(adcCsN), .adcRcN(adcRcN),
    .adcCe(adcCe), .adcA0(adcA0)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead();
    busAddr = A_DATA; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  // called with the first conversion cycle visible (k = 0)
  task automatic convCheck(input string req);
    int rcBad = 0;
    int ceBad = 0;
    for (int k = 0; k < SPAN + 2; k++) begin
      if (adcRcN != !(k < RC_W)) rcBad++;
      if (adcCe != ((k >= CE_DLY) && (k < CE_DLY + CE_W))) ceBad++;
      @(negedge clk);
    end
    chk({req, " R/C low window"}, rcBad, 0);
    chk({req, " R4 CE window"}, ceBad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 rcN", adcRcN, 1);
    chk("R1 ce", adcCe, 0);
    chk("R1 csN", adcCsN, 1);
    chk("R1 a0", adcA0, 0);
    chk("R1 rdata", busRData, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R7 / R8 / R9 readout table
    for (int i = 0; i < 6; i++) begin
      adcResult = VEC[i][19:8];
      busWrite(A_BSEL, {7'h55, VEC[i][20]});
      chk("R7 a0 set", adcA0, VEC[i][20]);
      busRead();
      chk("R8 byte", busRData, VEC[i][7:0]);
      chk("R8 ce pulse", adcCe, 1);
      chk("R8 rcN high", adcRcN, 1);
      chk("R9 a0 back to 0", adcA0, 0);
      @(negedge clk);
      chk("R8 ce one cycle", adcCe, 0);
      chk("R8 byte held", busRData, VEC[i][7:0]);
    end

    // R6 chip select, R2 start by write with arbitrary data
    busWrite(A_CTRL, 8'hFF);
    chk("R6 cs on", adcCsN, 0);
    busWrite(A_START, 8'hA5);
    convCheck("R2");

    // R3 timer edge, held high
    timerTick = 1'b1;
    @(negedge clk);
    convCheck("R3");
    begin
      int lows = 0;
      for (int k = 0; k < 2 * SPAN; k++) begin
        if (!adcRcN) lows++;
        @(negedge clk);
      end
      chk("R3 held tick starts once", lows, 0);
    end
    timerTick = 1'b0;
    @(negedge clk);
    timerTick = 1'b1;
    @(negedge clk);
    convCheck("R3 second edge");
    timerTick = 1'b0;

    // R5 / R6 / R10 requests during a conversion
    adcResult = 12'h123;
    busWrite(A_BSEL, 8'h01);
    busRead();
    busWrite(A_BSEL, 8'h01);
    chk("R10 setup byte", busRData, 8'h30);
    adcResult = 12'hFED;
    busWrite(A_START, 8'h00);           // k = 0 visible
    busRead();                          // k = 1 visible
    chk("R10 no read CE", adcCe, 0);
    chk("R10 rdata unchanged", busRData, 8'h30);
    chk("R10 a0 unchanged", adcA0, 1);
    busWrite(A_BSEL, 8'h00);            // k = 2
    chk("R6 bsel write ignored", adcA0, 1);
    busWrite(A_CTRL, 8'h00);            // k = 3
    chk("R6 ctrl write ignored", adcCsN, 0);
    busWrite(A_START, 8'h00);           // k = 4
    begin
      int n = 4;
      while (!adcRcN && n < 60) begin
        @(negedge clk);
        n++;
      end
      chk("R5 pulse not lengthened", n, RC_W);
    end
    repeat (SPAN) @(negedge clk);
    busRead();
    chk("R8 low nibble after conv", busRData, 8'hD0);
    chk("R9 a0 cleared", adcA0, 0);

    // R5 start ignored with chip select off
    busWrite(A_CTRL, 8'h00);
    chk("R6 cs off", adcCsN, 1);
    busWrite(A_START, 8'h00);
    begin
      int lows = 0;
      for (int k = 0; k < SPAN + 2; k++) begin
        if (!adcRcN) lows++;
        @(negedge clk);
      end
      chk("R5 start with cs off ignored", lows, 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule